// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a windowed register file in a 64-bit processor. It holds the current window pointer and four occupancy counters: windows that can still be saved into, windows that can be restored from, windows owned by another address space, and windows known to be clean. It also holds a 6-bit window-state register with a low "normal" field and a high "other" field.

A pipeline issues one request per cycle on `op`. Save and restore either move the pointer and adjust the counters, or leave all state alone and raise a trap. The trap can be a spill, a fill or a clean-window trap. The spill and fill trap types are built from the window-state register. The saved and restored requests are the follow-up to a trap handler and adjust the counters only. Flush-windows checks whether every window is already saved. Further op codes load each counter and the pointer, so that trap handlers and tests can place the block in any state.

All outputs are registered. A request sampled at a rising edge shows its result after that edge. Counters are `CW` bits wide and wrap freely.

Top module: `win_spill_ctl`

## Requirements
- R1: After reset (rst high at a clock edge) cansave is NWIN-2, and canrestore, otherwin, cleanwin, win_ptr, wstate, trap_valid and trap_type are all 0. trap_valid is high for exactly the cycle after a trapping request, and trap_type is 0 whenever trap_valid is low.
- R2: A save (op=1) with cansave 0 raises a spill trap and leaves every counter and win_ptr unchanged.
- R3: A save with cansave non-zero and cleanwin equal to canrestore raises a clean-window trap of type 0x024 and changes no counter or pointer.
- R4: A save that does not trap decrements cansave and increments canrestore. It steps win_ptr down by one, and win_ptr goes from 0 to NWIN-1.
- R5: A restore (op=2) with canrestore 0 raises a fill trap and changes no state. Otherwise it increments cansave, decrements canrestore, and steps win_ptr up by one, with NWIN-1 going to 0.
- R6: With otherwin 0, a spill or fill trap type is the base (spill 0x080, fill 0x0C0) ORed with wstate[2:0] shifted left by 2.
- R7: With otherwin non-zero, a spill or fill trap type is the base ORed with 0x020 and with wstate[5:3] shifted left by 2.
- R8: Saved (op=3) increments cansave. It decrements otherwin when otherwin is non-zero, and otherwise decrements canrestore.
- R9: Restored (op=4) increments canrestore and increments cleanwin only while cleanwin is below NWIN-1. It decrements otherwin when otherwin is non-zero, and otherwise decrements cansave.
- R10: Flush-windows (op=5) raises a spill trap when cansave differs from NWIN-2 and otherwise does nothing.
- R11: A trap raised in the same cycle as a window-state write (ws_we=1) takes its type from the old wstate. The new wstate is visible after that edge and governs later traps.
- R12: Op codes 8, 9, 10 and 11 load op_data into cansave, canrestore, otherwin and cleanwin. Op code 12 loads win_ptr, and is ignored when op_data is NWIN or more. Op 0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Request code, 0 = idle |
| op_data | input | CW | Value for load requests |
| ws_we | input | 1 | Window-state write enable |
| ws_din | input | 6 | New window-state value |
| win_ptr | output | CW | Current window pointer |
| cansave | output | CW | Windows available to save into |
| canrestore | output | CW | Windows available to restore from |
| otherwin | output | CW | Windows owned by another space |
| cleanwin | output | CW | Clean windows |
| wstate | output | 6 | Window-state register (other field [5:3], normal field [2:0]) |
| trap_valid | output | 1 | One-cycle trap strobe |
| trap_type | output | 9 | Trap type, 0 when no trap |

## Verification
A window-state write and a trapping save or restore can land on the same clock edge, and the trap type must come from the value being replaced. The bench provokes this by raising ws_we with a new value in the same cycle as a save with cansave at 0. It expects a trap type built from the old normal field and then reads the new value back on wstate. A second save then has to produce a trap type built from the new field, which shows that the write took effect on that edge and not later.

// File: rtl/win_pkg.sv
package win_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_SAVE      = 4'd1,
    OP_RESTORE   = 4'd2,
    OP_SAVED     = 4'd3,
    OP_RESTORED  = 4'd4,
    OP_FLUSH     = 4'd5,
    OP_LD_SAVE   = 4'd8,
    OP_LD_REST   = 4'd9,
    OP_LD_OTHER  = 4'd10,
    OP_LD_CLEAN  = 4'd11,
    OP_LD_PTR    = 4'd12
  } win_op_e;

  localparam int TTW = 9;
  localparam int WSW = 6;
  localparam logic [TTW-1:0] TT_SPILL = 9'h080;
  localparam logic [TTW-1:0] TT_FILL  = 9'h0C0;
  localparam logic [TTW-1:0] TT_CLEAN = 9'h024;
  localparam logic [TTW-1:0] TT_OTHER = 9'h020;
endpackage

// File: rtl/win_trap_enc.sv
module win_trap_enc
  import win_pkg::*;
(
  input  logic [TTW-1:0] base,
  input  logic           other_nz,
  input  logic [WSW-1:0] ws,
  output logic [TTW-1:0] tt
);
  logic [TTW-1:0] fld;
  always_comb begin
    if (other_nz) fld = TT_OTHER | {4'b0, ws[5:3], 2'b00};
    else          fld = {4'b0, ws[2:0], 2'b00};
    tt = base | fld;
  end
endmodule

// File: rtl/win_ptr_step.sv
module win_ptr_step #(
  parameter int NWIN = 6,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] up,
  output logic [CW-1:0] down
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);
  generate
    if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
      always_comb begin
        up   = cur + 1'b1;
        down = cur - 1'b1;
      end
    end else begin : g_mod
      always_comb begin
        up   = (cur == LAST) ? '0 : cur + 1'b1;
        down = (cur == '0) ? LAST : cur - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/win_spill_ctl.sv
module win_spill_ctl
  import win_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic [CW-1:0] op_data,
  input  logic          ws_we,
  input  logic [5:0]    ws_din,
  output logic [CW-1:0] win_ptr,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic [CW-1:0] otherwin,
  output logic [CW-1:0] cleanwin,
  output logic [5:0]    wstate,
  output logic          trap_valid,
  output logic [8:0]    trap_type
);
  localparam logic [CW-1:0] CS_INIT   = CW'(NWIN - 2);
  localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);
  localparam logic [CW:0]   PTR_LIM   = (CW+1)'(NWIN);

  logic [CW-1:0]  ptr_up, ptr_dn;
  logic [CW-1:0]  n_ptr, n_cs, n_cr, n_ow, n_cw;
  logic           n_trap, use_clean;
  logic [TTW-1:0] tbase, enc_tt, n_tt;
  win_op_e        opc;

  assign opc = win_op_e'(op);

  win_ptr_step #(.NWIN(NWIN), .CW(CW)) u_step (
    .cur(win_ptr), .up(ptr_up), .down(ptr_dn)
  );

  win_trap_enc u_enc (
    .base(tbase), .other_nz(otherwin != '0), .ws(wstate), .tt(enc_tt)
  );

  always_comb begin
    n_ptr = win_ptr; n_cs = cansave; n_cr = canrestore;
    n_ow = otherwin; n_cw = cleanwin;
    n_trap = 1'b0; use_clean = 1'b0; tbase = TT_SPILL;
    case (opc)
      OP_SAVE: begin
        if (cansave == '0) begin
          n_trap = 1'b1;
        end else if (cleanwin == canrestore) begin
          n_trap = 1'b1; use_clean = 1'b1;
        end else begin
          n_cs = cansave - 1'b1; n_cr = canrestore + 1'b1; n_ptr = ptr_dn;
        end
      end
      OP_RESTORE: begin
        tbase = TT_FILL;
        if (canrestore == '0) n_trap = 1'b1;
        else begin
          n_cs = cansave + 1'b1; n_cr = canrestore - 1'b1; n_ptr = ptr_up;
        end
      end
      OP_SAVED: begin
        n_cs = cansave + 1'b1;
        if (otherwin != '0) n_ow = otherwin - 1'b1;
        else                n_cr = canrestore - 1'b1;
      end
      OP_RESTORED: begin
        n_cr = canrestore + 1'b1;
        if (cleanwin < CLEAN_MAX) n_cw = cleanwin + 1'b1;
        if (otherwin != '0) n_ow = otherwin - 1'b1;
        else                n_cs = cansave - 1'b1;
      end
      OP_FLUSH:    n_trap = (cansave != CS_INIT);
      OP_LD_SAVE:  n_cs = op_data;
      OP_LD_REST:  n_cr = op_data;
      OP_LD_OTHER: n_ow = op_data;
      OP_LD_CLEAN: n_cw = op_data;
      OP_LD_PTR:   if ({1'b0, op_data} < PTR_LIM) n_ptr = op_data;
      default: ;
    endcase
    if (!n_trap)        n_tt = '0;
    else if (use_clean) n_tt = TT_CLEAN;
    else                n_tt = enc_tt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_ptr <= '0; cansave <= CS_INIT; canrestore <= '0;
      otherwin <= '0; cleanwin <= '0; wstate <= '0;
      trap_valid <= 1'b0; trap_type <= '0;
    end else begin
      win_ptr <= n_ptr; cansave <= n_cs; canrestore <= n_cr;
      otherwin <= n_ow; cleanwin <= n_cw;
      if (ws_we) wstate <= ws_din;
      trap_valid <= n_trap; trap_type <= n_tt;
    end
  end
endmodule

// File: rtl/win_spill_ctl_chk.sv
module win_spill_ctl_chk
  import win_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int CW   = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op,
  input logic [CW-1:0] win_ptr,
  input logic [CW-1:0] cansave,
  input logic [CW-1:0] canrestore,
  input logic [CW-1:0] cleanwin,
  input logic          trap_valid,
  input logic [8:0]    trap_type
);
  // R1
  no_type_without_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> trap_type == 9'h000);
  // R2
  spill_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SAVE && cansave == '0) |=>
      trap_valid && trap_type[7:6] == 2'b10 && $stable(cansave) && $stable(win_ptr));
  // R3
  clean_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SAVE && cansave != '0 && cleanwin == canrestore) |=>
      trap_valid && trap_type == 9'h024 && $stable(canrestore));
  // R4
  save_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SAVE && cansave != '0 && cleanwin != canrestore) |=>
      !trap_valid && cansave == CW'($past(cansave) - 1'b1) &&
      canrestore == CW'($past(canrestore) + 1'b1));
  // R5
  fill_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RESTORE && canrestore == '0) |=>
      trap_valid && trap_type[7:6] == 2'b11 && $stable(win_ptr));
  // R9
  clean_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RESTORED && cleanwin == CW'(NWIN - 1)) |=> cleanwin == CW'(NWIN - 1));
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FLUSH && cansave == CW'(NWIN - 2)) |=> !trap_valid);
  // R12
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, win_ptr} < (CW+1)'(NWIN));
endmodule

bind win_spill_ctl win_spill_ctl_chk #(.NWIN(NWIN), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .op(op), .win_ptr(win_ptr), .cansave(cansave),
  .canrestore(canrestore), .cleanwin(cleanwin),
  .trap_valid(trap_valid), .trap_type(trap_type)
);

// File: tb/tb_win_spill_ctl.sv
module tb_win_spill_ctl;
  localparam int NWIN = 6;
  localparam int CW   = $clog2(NWIN);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    op = 4'd0;
  logic [CW-1:0] op_data = '0;
  logic          ws_we = 1'b0;
  logic [5:0]    ws_din = '0;
  logic [CW-1:0] win_ptr, cansave, canrestore, otherwin, cleanwin;
  logic [5:0]    wstate;
  logic          trap_valid;
  logic [8:0]    trap_type;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  win_spill_ctl #(.NWIN(NWIN)) dut (
    .clk(clk), .rst(rst), .op(op), .op_data(op_data), .ws_we(ws_we),
    .ws_din(ws_din), .win_ptr(win_ptr), .cansave(cansave),
    .canrestore(canrestore), .otherwin(otherwin), .cleanwin(cleanwin),
    .wstate(wstate), .trap_valid(trap_valid), .trap_type(trap_type)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic do_op(input int code, input int data);
    @(negedge clk);
    op = 4'(code); op_data = CW'(data);
    @(negedge clk);
    op = 4'd0;
  endtask

  task automatic set_ws(input int v);
    @(negedge clk);
    ws_we = 1'b1; ws_din = 6'(v);
    @(negedge clk);
    ws_we = 1'b0;
  endtask

  task automatic setup(input int cs, input int cr, input int ow, input int cw, input int p);
    do_op(8, cs); do_op(9, cr); do_op(10, ow); do_op(11, cw); do_op(12, p);
  endtask

  task automatic t_reset;
    chk("R1 cansave", cansave, NWIN - 2);
    chk("R1 canrestore", canrestore, 0);
    chk("R1 otherwin", otherwin, 0);
    chk("R1 cleanwin", cleanwin, 0);
    chk("R1 win_ptr", win_ptr, 0);
    chk("R1 trap", {trap_valid, trap_type}, 0);
  endtask

  task automatic t_clean;
    setup(4, 2, 0, 2, 3);
    do_op(1, 0);
    chk("R3 trap_valid", trap_valid, 1);
    chk("R3 trap_type", trap_type, 'h024);
    chk("R3 cansave", cansave, 4);
    chk("R3 win_ptr", win_ptr, 3);
    @(negedge clk);
    chk("R1 strobe one cycle", {trap_valid, trap_type}, 0);
  endtask

  task automatic t_save_restore;
    setup(4, 0, 0, 5, 0);
    do_op(1, 0);
    chk("R4 cansave", cansave, 3);
    chk("R4 canrestore", canrestore, 1);
    chk("R4 ptr wrap", win_ptr, NWIN - 1);
    chk("R4 no trap", trap_valid, 0);
    do_op(2, 0);
    chk("R5 cansave", cansave, 4);
    chk("R5 canrestore", canrestore, 0);
    chk("R5 ptr wrap", win_ptr, 0);
    set_ws('b101_011);
    do_op(2, 0);
    chk("R5 fill trap", trap_valid, 1);
    chk("R6 fill type", trap_type, 'h0CC);
    chk("R5 ptr held", win_ptr, 0);
  endtask

  task automatic t_other;
    setup(3, 0, 2, 0, 1);
    do_op(2, 0);
    chk("R7 fill other type", trap_type, 'h0F4);
    do_op(8, 0);
    do_op(1, 0);
    chk("R7 spill other type", trap_type, 'h0B4);
    chk("R2 cansave held", cansave, 0);
    chk("R2 ptr held", win_ptr, 1);
  endtask

  task automatic t_saved;
    setup(1, 3, 2, 0, 0);
    do_op(3, 0);
    chk("R8 cansave", cansave, 2);
    chk("R8 otherwin dec", otherwin, 1);
    chk("R8 canrestore kept", canrestore, 3);
    do_op(10, 0);
    do_op(3, 0);
    chk("R8 cansave again", cansave, 3);
    chk("R8 canrestore dec", canrestore, 2);
  endtask

  task automatic t_restored;
    setup(3, 1, 0, NWIN - 1, 0);
    do_op(4, 0);
    chk("R9 canrestore", canrestore, 2);
    chk("R9 cleanwin capped", cleanwin, NWIN - 1);
    chk("R9 cansave dec", cansave, 2);
    setup(3, 1, 1, NWIN - 2, 0);
    do_op(4, 0);
    chk("R9 cleanwin inc", cleanwin, NWIN - 1);
    chk("R9 otherwin dec", otherwin, 0);
    chk("R9 cansave kept", cansave, 3);
  endtask

  task automatic t_flush;
    setup(NWIN - 2, 0, 0, 0, 0);
    do_op(5, 0);
    chk("R10 flush quiet", trap_valid, 0);
    do_op(8, NWIN - 3);
    do_op(5, 0);
    chk("R10 flush spill", trap_type, 'h08C);
    chk("R10 flush strobe", trap_valid, 1);
  endtask

  task automatic t_concurrent;
    setup(0, 0, 0, 0, 2);
    set_ws('b000_001);
    @(negedge clk);
    op = 4'd1; ws_we = 1'b1; ws_din = 6'b000_010;
    @(negedge clk);
    op = 4'd0; ws_we = 1'b0;
    chk("R11 old field used", trap_type, 'h084);
    chk("R11 new wstate", wstate, 'b000_010);
    do_op(1, 0);
    chk("R11 new field used", trap_type, 'h088);
  endtask

  task automatic t_loads;
    setup(0, 0, 0, 0, 4);
    chk("R12 ptr load", win_ptr, 4);
    do_op(12, NWIN);
    chk("R12 ptr out of range", win_ptr, 4);
    do_op(12, NWIN + 1);
    chk("R12 ptr out of range 2", win_ptr, 4);
    chk("R12 otherwin load", otherwin, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_save_restore();
    t_other();
    t_saved();
    t_restored();
    t_flush();
    t_concurrent();
    t_loads();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule